// File: doc/BRIEF.md
# Multi-group power-up sequencer

This block turns a set of power-module groups (three by default) on and off in a fixed order. It uses the measured rail voltage of each group to decide when it may move to the next one. A sequence-on request enables the lowest group first. The next group is enabled only after the rail of the group just enabled has reached that group's own ramp-high level. A sequence-off request works from the highest group downward. Each step waits until the group just disabled has fallen under its own ramp-low level.

The rail measurements and the per-group ramp levels are unsigned millivolt codes of equal width. They are plain level inputs that the block compares every cycle, so a level changed at run time takes effect on the next comparison. The sequencer also does the following:
- It accepts per-group on and off requests while it is idle.
- A fault request makes it run a full power-down.
- A programmable wait limit bounds every ramp wait.
- A status LED per group shows that the group is enabled and its rail is at or above its ramp-high level.

There is no data stream through the block, so it has no valid/ready handshake and applies no back-pressure. A request that arrives while the block cannot take it is dropped, not held. The caller watches `busy` and `done` and repeats the request if it is still needed.

Top module: `pwrseq_top`

## Requirements
- R1: A sequence-on request taken while idle enables group 0 at once. It then enables group k+1 only after a cycle in which group k's rail code is greater than or equal to group k's ramp-high code. A rail exactly equal to the ramp-high code counts as reached.
- R2: A sequence-off request taken while idle disables the highest group at once. It then disables group k-1 only after a cycle in which group k's rail code is strictly below group k's ramp-low code. A rail equal to the ramp-low code does not allow the step.
- R3: Each group compares against its own ramp-high and ramp-low inputs. A change to these inputs during a wait is used in the very next cycle's comparison.
- R4: While idle, a one-cycle per-group on or off request sets or clears that group's enable on the next clock edge, without raising `busy`. If on and off are requested for the same group in the same cycle, off wins.
- R5: A fault request while idle or during power-up starts a power-down from the highest group. This power-down follows the R2 rules. A fault request during power-down is ignored.
- R6: A ramp wait that is not satisfied for `wait_limit`+1 cycles sets `timeout_err`. On power-up, the sequencer then disables the group it was waiting on and powers down the groups below it. On power-down, it returns to idle and leaves the remaining groups enabled. `timeout_err` stays set until the next sequence-on or sequence-off request is taken.
- R7: `busy` is high whenever a sequence is in progress. `done` is a single-cycle pulse, raised in the same cycle that `busy` falls, when a sequence finishes without a timeout. This includes the power-down started by a fault or by a power-up timeout.
- R8: While busy, sequence requests and per-group requests have no effect. While idle, the priority is fault first, then sequence-off, then sequence-on, then per-group requests.
- R9: A group's LED bit is high one cycle after a cycle in which that group was enabled and its rail was at or above its ramp-high code. Otherwise the bit is low.
- R10: Enables, `busy` and `timeout_err` change on the clock edge that samples the deciding request or rail value. There is no additional pipeline stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| seq_on_req | input | 1 | Start an ordered power-up |
| seq_off_req | input | 1 | Start an ordered power-down |
| fault_req | input | 1 | Rail-monitor fault; forces a power-down |
| grp_on_req | input | NGRP | Per-group enable request, idle only |
| grp_off_req | input | NGRP | Per-group disable request, idle only |
| rail_mv | input | NGRP*VW | Measured rail code per group, group g at bits g*VW upward |
| ramp_hi_mv | input | NGRP*VW | Ramp-high level per group, same packing |
| ramp_lo_mv | input | NGRP*VW | Ramp-low level per group, same packing |
| wait_limit | input | TW | Ramp wait limit in cycles |
| grp_en | output | NGRP | Group enable lines |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle sequence completion pulse |
| timeout_err | output | 1 | Sticky ramp-wait timeout flag |
| led | output | NGRP | Per-group powered-up status |

## Verification
A request driven before edge n shows up on `grp_en`, `busy` and `timeout_err` right after edge n. A rail or ramp-level change driven before edge n moves the sequence at edge n. `done` is raised at the same edge as the final step. The LED lags the enable-and-rail condition by one more edge. A timeout falls on the (`wait_limit`+1)th edge after the edge that opened the wait. The bench drives inputs on falling edges and samples on the next falling edge, one edge later. For timeouts it counts exactly `wait_limit` quiet samples before it expects the error. In random runs, a rail model checks every enable edge against the rail value that the deciding clock edge saw.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_RISE = 2'd1,
    SEQ_FALL = 2'd2
  } seq_state_e;

  function automatic int unsigned idx_bits(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/pwrseq_ramp_cmp.sv
// Per-group ramp comparator: at-or-above high level, strictly below low level.
module pwrseq_ramp_cmp #(
  parameter int VW = 12
) (
  input  logic [VW-1:0] rail_mv,
  input  logic [VW-1:0] hi_mv,
  input  logic [VW-1:0] lo_mv,
  output logic          reached_hi,
  output logic          under_lo
);
  assign reached_hi = (rail_mv >= hi_mv);
  assign under_lo   = (rail_mv <  lo_mv);
endmodule

// File: rtl/pwrseq_wait_timer.sv
// Wait counter: cleared by restart, counts up to limit and holds there.
module pwrseq_wait_timer #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic [TW-1:0] limit,
  output logic          expired
);
  logic [TW-1:0] cnt_q;

  assign expired = (cnt_q == limit);

  always_ff @(posedge clk) begin
    if (!rst_n)        cnt_q <= '0;
    else if (restart)  cnt_q <= '0;
    else if (!expired) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/pwrseq_ctrl.sv
// Sequencing state machine: ordered enables, ramp waits, fault and timeout handling.
module pwrseq_ctrl
  import pwrseq_pkg::*;
#(
  parameter int NGRP = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            seq_on,
  input  logic            seq_off,
  input  logic            fault,
  input  logic [NGRP-1:0] grp_on,
  input  logic [NGRP-1:0] grp_off,
  input  logic [NGRP-1:0] reached_hi,
  input  logic [NGRP-1:0] under_lo,
  input  logic            expired,
  output logic [NGRP-1:0] grp_en,
  output logic            busy,
  output logic            done,
  output logic            timeout_err,
  output logic            timer_restart
);
  localparam int unsigned IW = idx_bits(NGRP);
  localparam logic [IW-1:0] TOP_IDX = IW'(NGRP - 1);

  seq_state_e      state_q;
  logic [IW-1:0]   idx_q;
  logic [NGRP-1:0] en_q;
  logic            done_q;
  logic            err_q;
  logic            sel_hi;
  logic            sel_lo;
  logic            step;

  always_comb begin
    sel_hi = reached_hi[idx_q];
    sel_lo = under_lo[idx_q];
    step   = ((state_q == SEQ_RISE) && (fault || sel_hi || expired)) ||
             ((state_q == SEQ_FALL) && (sel_lo || expired));
    timer_restart = (state_q == SEQ_IDLE) || step;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      idx_q   <= '0;
      en_q    <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        SEQ_IDLE: begin
          if (fault) begin
            state_q       <= SEQ_FALL;
            idx_q         <= TOP_IDX;
            en_q[TOP_IDX] <= 1'b0;
          end else if (seq_off) begin
            state_q       <= SEQ_FALL;
            idx_q         <= TOP_IDX;
            en_q[TOP_IDX] <= 1'b0;
            err_q         <= 1'b0;
          end else if (seq_on) begin
            state_q <= SEQ_RISE;
            idx_q   <= '0;
            en_q[0] <= 1'b1;
            err_q   <= 1'b0;
          end else begin
            en_q <= (en_q | grp_on) & ~grp_off;
          end
        end
        SEQ_RISE: begin
          if (fault) begin
            state_q       <= SEQ_FALL;
            idx_q         <= TOP_IDX;
            en_q[TOP_IDX] <= 1'b0;
          end else if (sel_hi) begin
            if (idx_q == TOP_IDX) begin
              state_q <= SEQ_IDLE;
              done_q  <= 1'b1;
            end else begin
              idx_q                 <= idx_q + 1'b1;
              en_q[idx_q + 1'b1]    <= 1'b1;
            end
          end else if (expired) begin
            err_q       <= 1'b1;
            state_q     <= SEQ_FALL;
            en_q[idx_q] <= 1'b0;
          end
        end
        SEQ_FALL: begin
          if (sel_lo) begin
            if (idx_q == '0) begin
              state_q <= SEQ_IDLE;
              done_q  <= 1'b1;
            end else begin
              idx_q              <= idx_q - 1'b1;
              en_q[idx_q - 1'b1] <= 1'b0;
            end
          end else if (expired) begin
            err_q   <= 1'b1;
            state_q <= SEQ_IDLE;
          end
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  assign grp_en      = en_q;
  assign busy        = (state_q != SEQ_IDLE);
  assign done        = done_q;
  assign timeout_err = err_q;
endmodule

// File: rtl/pwrseq_led.sv
// Status LEDs: group enabled and rail at or above its ramp-high level.
module pwrseq_led #(
  parameter int NGRP = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NGRP-1:0] grp_en,
  input  logic [NGRP-1:0] reached_hi,
  output logic [NGRP-1:0] led
);
  always_ff @(posedge clk) begin
    if (!rst_n) led <= '0;
    else        led <= grp_en & reached_hi;
  end
endmodule

// File: rtl/pwrseq_top.sv
module pwrseq_top #(
  parameter int NGRP = 3,
  parameter int VW   = 12,
  parameter int TW   = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               seq_on_req,
  input  logic               seq_off_req,
  input  logic               fault_req,
  input  logic [NGRP-1:0]    grp_on_req,
  input  logic [NGRP-1:0]    grp_off_req,
  input  logic [NGRP*VW-1:0] rail_mv,
  input  logic [NGRP*VW-1:0] ramp_hi_mv,
  input  logic [NGRP*VW-1:0] ramp_lo_mv,
  input  logic [TW-1:0]      wait_limit,
  output logic [NGRP-1:0]    grp_en,
  output logic               busy,
  output logic               done,
  output logic               timeout_err,
  output logic [NGRP-1:0]    led
);
  logic [NGRP-1:0] reached_hi;
  logic [NGRP-1:0] under_lo;
  logic            expired;
  logic            timer_restart;

  for (genvar g = 0; g < NGRP; g++) begin : g_cmp
    pwrseq_ramp_cmp #(.VW(VW)) u_cmp (
      .rail_mv    (rail_mv[g*VW +: VW]),
      .hi_mv      (ramp_hi_mv[g*VW +: VW]),
      .lo_mv      (ramp_lo_mv[g*VW +: VW]),
      .reached_hi (reached_hi[g]),
      .under_lo   (under_lo[g])
    );
  end

  pwrseq_wait_timer #(.TW(TW)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (timer_restart),
    .limit   (wait_limit),
    .expired (expired)
  );

  pwrseq_ctrl #(.NGRP(NGRP)) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .seq_on        (seq_on_req),
    .seq_off       (seq_off_req),
    .fault         (fault_req),
    .grp_on        (grp_on_req),
    .grp_off       (grp_off_req),
    .reached_hi    (reached_hi),
    .under_lo      (under_lo),
    .expired       (expired),
    .grp_en        (grp_en),
    .busy          (busy),
    .done          (done),
    .timeout_err   (timeout_err),
    .timer_restart (timer_restart)
  );

  pwrseq_led #(.NGRP(NGRP)) u_led (
    .clk        (clk),
    .rst_n      (rst_n),
    .grp_en     (grp_en),
    .reached_hi (reached_hi),
    .led        (led)
  );
endmodule

// File: rtl/pwrseq_chk.sv
module pwrseq_chk #(
  parameter int NGRP = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NGRP-1:0] grp_en,
  input logic            busy,
  input logic            done,
  input logic            timeout_err,
  input logic [NGRP-1:0] led
);
  for (genvar i = 1; i < NGRP; i++) begin : g_up
    // R1
    up_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(grp_en[i]) && $past(busy)) |-> $past(grp_en[i-1]));
  end

  for (genvar i = 0; i < NGRP - 1; i++) begin : g_down
    // R2
    down_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(grp_en[i]) && $past(busy)) |-> !$past(grp_en[i+1]));
  end

  for (genvar i = 0; i < NGRP; i++) begin : g_led
    // R9
    led_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      led[i] |-> $past(grp_en[i]));
  end

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7
  done_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  // R6
  err_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout_err) |-> $past(busy));
endmodule

bind pwrseq_top pwrseq_chk #(.NGRP(NGRP)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .grp_en      (grp_en),
  .busy        (busy),
  .done        (done),
  .timeout_err (timeout_err),
  .led         (led)
);

// File: tb/pwrseq_top_test.sv
`timescale 1ns/1ps
module pwrseq_top_test;
  localparam int NGRP = 3;
  localparam int VW   = 12;
  localparam int TW   = 16;
  localparam int TL   = 20;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               seq_on_req = 1'b0, seq_off_req = 1'b0, fault_req = 1'b0;
  logic [NGRP-1:0]    grp_on_req = '0, grp_off_req = '0;
  logic [NGRP*VW-1:0] rail_mv, ramp_hi_mv, ramp_lo_mv;
  logic [TW-1:0]      wait_limit = 16'd1000;
  logic [NGRP-1:0]    grp_en, led;
  logic               busy, done, timeout_err;

  logic [VW-1:0] rail [NGRP];
  logic [VW-1:0] hi   [NGRP];
  logic [VW-1:0] lo   [NGRP];

  int  n_chk = 0, n_bad = 0;
  bit  finished = 0;
  bit  manual = 0, mon_on = 0;
  int  udly [NGRP], ddly [NGRP], ucnt [NGRP], dcnt [NGRP];
  logic [NGRP-1:0] pen = '0;

  always #2.5 clk = ~clk;

  always_comb begin
    for (int i = 0; i < NGRP; i++) begin
      rail_mv[i*VW +: VW]    = rail[i];
      ramp_hi_mv[i*VW +: VW] = hi[i];
      ramp_lo_mv[i*VW +: VW] = lo[i];
    end
  end

  pwrseq_top #(.NGRP(NGRP), .VW(VW), .TW(TW)) uut (
    .clk(clk), .rst_n(rst_n), .seq_on_req(seq_on_req), .seq_off_req(seq_off_req),
    .fault_req(fault_req), .grp_on_req(grp_on_req), .grp_off_req(grp_off_req),
    .rail_mv(rail_mv), .ramp_hi_mv(ramp_hi_mv), .ramp_lo_mv(ramp_lo_mv),
    .wait_limit(wait_limit), .grp_en(grp_en), .busy(busy), .done(done),
    .timeout_err(timeout_err), .led(led)
  );

  function automatic bit may_rise(input logic [VW-1:0] r, input logic [VW-1:0] h);
    return r >= h;
  endfunction

  function automatic bit may_fall(input logic [VW-1:0] r, input logic [VW-1:0] l);
    return r < l;
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask

  task automatic pulse_on();  seq_on_req = 1;  tick(); seq_on_req = 0;  endtask
  task automatic pulse_off(); seq_off_req = 1; tick(); seq_off_req = 0; endtask

  task automatic wait_done(input string req);
    bit seen = 0;
    for (int k = 0; k < 5000 && !seen; k++) begin
      tick();
      if (done) seen = 1;
    end
    chk(req, "done pulse reached", 32'(seen), 32'd1);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  // Rail model and order monitor; monitor reads rails before this edge's update.
  always @(negedge clk) begin
    if (rst_n && !manual) begin
      for (int i = 0; i < NGRP; i++) begin
        if (mon_on && grp_en[i] && !pen[i] && i > 0)
          chk("R1", "up step saw prior rail at ramp-high",
              32'(pen[i-1] && may_rise(rail[i-1], hi[i-1])), 32'd1);
        if (mon_on && !grp_en[i] && pen[i] && i < NGRP - 1)
          chk("R2", "down step saw upper rail under ramp-low",
              32'(!pen[i+1] && may_fall(rail[i+1], lo[i+1])), 32'd1);
      end
      for (int i = 0; i < NGRP; i++) begin
        if (grp_en[i]) begin
          dcnt[i] = 0;
          if (ucnt[i] >= udly[i]) rail[i] = 12'd2000; else ucnt[i]++;
        end else begin
          ucnt[i] = 0;
          if (dcnt[i] >= ddly[i]) rail[i] = 12'd0; else dcnt[i]++;
        end
      end
    end
    pen = grp_en;
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk("WD", "watchdog expired", 32'd1, 32'd0);
    finish_run();
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < NGRP; i++) begin
      rail[i] = '0; hi[i] = 12'd800; lo[i] = 12'd50;
      udly[i] = 5; ddly[i] = 5; ucnt[i] = 0; dcnt[i] = 0;
    end
    repeat (3) tick();
    chk("R7", "reset enables", 32'(grp_en), 32'd0);
    chk("R7", "reset busy/done/err", {busy, done, timeout_err}, 32'd0);
    chk("R9", "reset led", 32'(led), 32'd0);
    rst_n = 1;
    tick();

    // Automatic sequence up and down
    mon_on = 1;
    pulse_on();
    chk("R10", "first enable one edge after request", 32'(grp_en), 32'b001);
    chk("R7", "busy during power-up", 32'(busy), 32'd1);
    wait_done("R1");
    chk("R1", "all groups on", 32'(grp_en), 32'b111);
    chk("R7", "busy low at done", 32'(busy), 32'd0);
    chk("R9", "led all on", 32'(led), 32'b111);
    pulse_off();
    chk("R2", "top group off first", 32'(grp_en), 32'b011);
    wait_done("R2");
    chk("R2", "all groups off", 32'(grp_en), 32'b000);
    chk("R9", "led all off", 32'(led), 32'b000);
    mon_on = 0;

    // Threshold boundaries and run-time threshold change
    manual = 1; tick();
    hi[0] = 500; hi[1] = 600; hi[2] = 800;
    pulse_on();
    chk("R1", "group 0 on", 32'(grp_en), 32'b001);
    rail[0] = 499;
    repeat (3) tick();
    chk("R1", "below ramp-high holds", 32'(grp_en), 32'b001);
    rail[0] = 500; tick();
    chk("R1", "equal to ramp-high advances", 32'(grp_en), 32'b011);
    rail[1] = 400; repeat (2) tick();
    chk("R3", "group 1 waits on its own level", 32'(grp_en), 32'b011);
    hi[1] = 400; tick();
    chk("R3", "lowered level used next cycle", 32'(grp_en), 32'b111);
    rail[2] = 2000; tick();
    chk("R7", "done on last step", {30'd0, done, busy}, 32'b10);
    tick();
    chk("R7", "done lasts one cycle", 32'(done), 32'd0);

    // Ignored while busy; ramp-low boundary
    pulse_off();
    chk("R2", "power-down starts", 32'(grp_en), 32'b011);
    seq_on_req = 1; grp_on_req = 3'b100; tick(); seq_on_req = 0; grp_on_req = '0;
    chk("R8", "requests ignored while busy", 32'(grp_en), 32'b011);
    fault_req = 1; tick(); fault_req = 0;
    chk("R5", "fault ignored during power-down", 32'(grp_en), 32'b011);
    rail[2] = 10; tick();
    chk("R2", "under ramp-low advances", 32'(grp_en), 32'b001);
    rail[1] = 50; repeat (2) tick();
    chk("R2", "equal to ramp-low holds", 32'(grp_en), 32'b001);
    rail[1] = 49; tick();
    chk("R2", "group 0 off", 32'(grp_en), 32'b000);
    rail[0] = 0; tick();
    chk("R7", "done after power-down", 32'(done), 32'd1);
    rail[2] = 0;

    // Individual group control
    grp_on_req = 3'b101; tick(); grp_on_req = '0;
    chk("R4", "individual on", 32'(grp_en), 32'b101);
    chk("R4", "no busy for individual", 32'(busy), 32'd0);
    grp_on_req = 3'b010; grp_off_req = 3'b010; tick(); grp_on_req = '0; grp_off_req = '0;
    chk("R4", "off wins over on", 32'(grp_en), 32'b101);
    grp_off_req = 3'b001; tick(); grp_off_req = '0;
    chk("R4", "individual off", 32'(grp_en), 32'b100);
    rail[2] = 800; tick();
    chk("R9", "led follows enable and rail", 32'(led), 32'b100);
    grp_off_req = 3'b100; tick(); grp_off_req = '0;
    tick();
    chk("R9", "led clears after disable", 32'(led), 32'b000);
    rail[2] = 0;

    // Fault during power-up
    hi[0] = 500; hi[1] = 500; hi[2] = 500;
    pulse_on();
    rail[0] = 600; tick();
    chk("R1", "group 1 on", 32'(grp_en), 32'b011);
    fault_req = 1; tick(); fault_req = 0;
    chk("R5", "fault starts power-down", {29'd0, busy, grp_en[1:0]}, 32'b111);
    tick();
    chk("R5", "group 1 off next", 32'(grp_en), 32'b001);
    tick();
    chk("R5", "group 0 off", 32'(grp_en), 32'b000);
    rail[0] = 0; tick();
    chk("R7", "done after fault power-down", 32'(done), 32'd1);

    // Power-up timeout
    wait_limit = TL;
    pulse_on();
    rail[0] = 600; tick();
    chk("R1", "waiting on group 1", 32'(grp_en), 32'b011);
    repeat (TL) tick();
    chk("R6", "no timeout before limit", {29'd0, timeout_err, grp_en[1:0]}, 32'b011);
    tick();
    chk("R6", "timeout disables waited group", {28'd0, timeout_err, busy, grp_en[1:0]}, 32'b1101);
    tick();
    chk("R6", "lower group powered down", 32'(grp_en), 32'b000);
    rail[0] = 0; tick();
    chk("R6", "error sticky at done", {29'd0, done, busy, timeout_err}, 32'b101);

    // Power-down timeout and error clear
    rail[0] = 600; rail[1] = 600; rail[2] = 600;
    pulse_on();
    chk("R6", "error cleared by accepted request", 32'(timeout_err), 32'd0);
    wait_done("R1");
    pulse_off();
    repeat (TL) tick();
    chk("R6", "power-down still waiting", {29'd0, timeout_err, grp_en[1:0]}, 32'b011);
    tick();
    chk("R6", "power-down timeout stops in idle",
        {27'd0, timeout_err, busy, grp_en}, 32'b10011);
    rail[0] = 0; rail[1] = 0; rail[2] = 0;
    pulse_off();
    chk("R8", "error cleared by sequence-off", 32'(timeout_err), 32'd0);
    wait_done("R2");
    chk("R2", "all off after retry", 32'(grp_en), 32'b000);

    // Random ramp levels and rail delays
    wait_limit = 1000;
    manual = 0; mon_on = 1; tick();
    for (int it = 0; it < 12; it++) begin
      for (int i = 0; i < NGRP; i++) begin
        hi[i] = 12'(100 + $urandom_range(1899));
        lo[i] = 12'(1 + $urandom_range(98));
        udly[i] = 1 + $urandom_range(29);
        ddly[i] = 1 + $urandom_range(29);
      end
      pulse_on();
      wait_done("R1");
      chk("R1", "random power-up all on", {28'd0, timeout_err, grp_en}, 32'b0111);
      chk("R9", "random leds", 32'(led), 32'b111);
      pulse_off();
      wait_done("R2");
      chk("R2", "random power-down all off", {28'd0, timeout_err, grp_en}, 32'b0000);
    end
    mon_on = 0;
    repeat (2) tick();
    finish_run();
  end
endmodule